// File: doc/BRIEF.md
# Security Attribution Region Checker

This block sorts each incoming address into one of three security classes: secure, non-secure, or secure-callable. It holds a small table of address regions. Each region has an inclusive lower and upper bound, its own enable bit and a tag that marks it as non-secure or secure-callable. The block compares a query address against every region in parallel. One cycle later it returns the class, a hit flag, the index of the matching region and a flag that reports overlapping regions.

Software-side logic loads the region table and a global control word through a single-cycle write port. While the global enable is clear, the block ignores the region table. Every address then takes a blanket fallback class, secure or non-secure, chosen in the global control word. A build with zero regions has no table at all, so it always answers with the fallback class.

Top module: `sar_checker`

## Requirements
- R1: A region matches an address when it is enabled and base <= addr <= limit, with both bounds included (unsigned 32-bit compare by default).
- R2: Each region's enable bit resets to 1 (enabled), with base and limit reset to 0. Writing control bit 0 = 0 takes the region out of every lookup.
- R3: The region control word (cfg_sel = 2) bit 1 picks the region tag: 0 is non-secure and 1 is secure-callable. The result codes on r_attr are 0 = secure, 1 = non-secure and 2 = secure-callable. Code 3 never appears, and code 2 only appears with r_hit = 1.
- R4: The global word (cfg_sel = 3) bit 0 is the unit enable, which resets to 0. Bit 1 is the fallback class, which resets to 0: 0 gives secure and 1 gives non-secure. While the unit is disabled, every result carries the fallback class, with r_hit = 0, r_idx = 0 and r_overlap = 0.
- R5: With NREG = 0, every query returns the fallback class with r_hit = 0, whatever the global enable bit holds.
- R6: With the unit enabled, an address that matches no enabled region returns secure, with r_hit = 0 and r_idx = 0.
- R7: With the unit enabled, an address that matches two or more enabled regions returns secure with r_hit = 1, r_overlap = 1, and r_idx set to the lowest matching region.
- R8: A query presented with q_valid = 1 produces r_valid = 1 and its result exactly one cycle later. r_valid is 0 in any cycle after a cycle without a query.
- R9: A configuration write (cfg_we = 1) takes effect in the cycle after it is accepted. A query in the same cycle as the write is classified with the old configuration.
- R10: After reset and before any query, r_valid = 0 and r_hit = 0.
- R11: With region 0 set to 0x10001000..0x10005000 non-secure and region 1 set to 0x10006000..0x10008000 secure-callable, addresses inside each span return that region's class and index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 base, 1 limit, 2 region control, 3 global control |
| cfg_idx | input | IW | Region index for cfg_sel 0..2; a value of NREG or above is ignored |
| cfg_wdata | input | AW | Write data |
| q_valid | input | 1 | Query valid |
| q_addr | input | AW | Query address |
| r_valid | output | 1 | Result valid, one cycle after q_valid |
| r_attr | output | 2 | Class: 0 secure, 1 non-secure, 2 secure-callable |
| r_hit | output | 1 | At least one enabled region matched while the unit was enabled |
| r_idx | output | IW | Lowest matching region index, 0 when there is no hit |
| r_overlap | output | 1 | Two or more enabled regions matched |

## Verification
The bound checker tests properties on every cycle. It checks the one-cycle link between q_valid and r_valid, the fallback class and cleared hit while the unit is off, and that a miss or an overlap always resolves to secure. It also checks that the class code stays legal and that secure-callable never appears without a hit. Some behaviours can only be shown by the scoreboard scenarios, because they depend on the exact configuration that was loaded. These are the inclusive bounds, the region index, the reset-enabled regions, the old-configuration view in the write cycle, and the zero-region build.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        SA_SECURE   = 2'd0,
        SA_NONSEC   = 2'd1,
        SA_CALLABLE = 2'd2
    } sa_attr_e;

    typedef enum logic [1:0] {
        CFG_BASE   = 2'd0,
        CFG_LIMIT  = 2'd1,
        CFG_CTRL   = 2'd2,
        CFG_GLOBAL = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/sar_cfg_regs.sv
module sar_cfg_regs #(
    parameter int NR      = 4,
    parameter int AW      = 32,
    parameter int IW      = 2,
    parameter bit PRESENT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [1:0]             sel,
    input  logic [IW-1:0]          idx,
    input  logic [AW-1:0]          wdata,
    output logic [NR-1:0][AW-1:0]  base,
    output logic [NR-1:0][AW-1:0]  limit,
    output logic [NR-1:0]          reg_en,
    output logic [NR-1:0]          reg_sc,
    output logic                   unit_en,
    output logic                   fb_ns
);
    import sar_pkg::*;

    typedef struct packed {
        logic [NR-1:0][AW-1:0] base;
        logic [NR-1:0][AW-1:0] limit;
        logic [NR-1:0]         en;
        logic [NR-1:0]         sc;
        logic                  unit_en;
        logic                  fb_ns;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (sel == CFG_GLOBAL) begin
                cfg_d.unit_en = wdata[0];
                cfg_d.fb_ns   = wdata[1];
            end else if (PRESENT && (int'(idx) < NR)) begin
                case (sel)
                    CFG_BASE:  cfg_d.base[idx]  = wdata;
                    CFG_LIMIT: cfg_d.limit[idx] = wdata;
                    default: begin
                        cfg_d.en[idx] = wdata[0];
                        cfg_d.sc[idx] = wdata[1];
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q         <= '0;
            cfg_q.en      <= '1;
        end else begin
            cfg_q         <= cfg_d;
        end
    end

    assign base    = cfg_q.base;
    assign limit   = cfg_q.limit;
    assign reg_en  = PRESENT ? cfg_q.en : '0;
    assign reg_sc  = cfg_q.sc;
    assign unit_en = PRESENT ? cfg_q.unit_en : 1'b0;
    assign fb_ns   = cfg_q.fb_ns;
endmodule

// File: rtl/sar_region_cmp.sv
module sar_region_cmp #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          en,
    output logic          match
);
    logic above_lo, below_hi;

    always_comb begin
        above_lo = (addr >= lo);
        below_hi = (addr <= hi);
        match    = en && above_lo && below_hi;
    end
endmodule

// File: rtl/sar_resolve.sv
module sar_resolve #(
    parameter int NR = 4,
    parameter int IW = 2
) (
    input  logic [NR-1:0] hits,
    input  logic [NR-1:0] sc,
    input  logic          unit_en,
    input  logic          fb_ns,
    output logic [1:0]    attr,
    output logic          hit,
    output logic [IW-1:0] idx,
    output logic          overlap
);
    import sar_pkg::*;

    logic [IW-1:0] low_idx;
    logic          multi;

    always_comb begin
        low_idx = '0;
        for (int i = NR - 1; i >= 0; i--) begin
            if (hits[i]) low_idx = IW'(i);
        end
        multi = ($countones(hits) > 1);
    end

    always_comb begin
        attr    = SA_SECURE;
        hit     = 1'b0;
        idx     = '0;
        overlap = 1'b0;
        if (!unit_en) begin
            attr = fb_ns ? SA_NONSEC : SA_SECURE;
        end else if (|hits) begin
            hit = 1'b1;
            idx = low_idx;
            if (multi) begin
                overlap = 1'b1;
                attr    = SA_SECURE;
            end else begin
                attr = sc[low_idx] ? SA_CALLABLE : SA_NONSEC;
            end
        end
    end
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
    parameter int  NREG = 4,
    parameter int  AW   = 32,
    localparam int NR   = (NREG > 0) ? NREG : 1,
    localparam int IW   = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [IW-1:0] cfg_idx,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          q_valid,
    input  logic [AW-1:0] q_addr,
    output logic          r_valid,
    output logic [1:0]    r_attr,
    output logic          r_hit,
    output logic [IW-1:0] r_idx,
    output logic          r_overlap
);
    localparam bit PRESENT = (NREG > 0);

    logic [NR-1:0][AW-1:0] base, limit;
    logic [NR-1:0]         reg_en, reg_sc, hits;
    logic                  unit_en, fb_ns;
    logic [1:0]            lk_attr;
    logic                  lk_hit, lk_ov;
    logic [IW-1:0]         lk_idx;

    sar_cfg_regs #(.NR(NR), .AW(AW), .IW(IW), .PRESENT(PRESENT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .idx(cfg_idx),
        .wdata(cfg_wdata), .base(base), .limit(limit), .reg_en(reg_en),
        .reg_sc(reg_sc), .unit_en(unit_en), .fb_ns(fb_ns)
    );

    for (genvar g = 0; g < NR; g++) begin : g_cmp
        sar_region_cmp #(.AW(AW)) u_cmp (
            .addr(q_addr), .lo(base[g]), .hi(limit[g]),
            .en(reg_en[g]), .match(hits[g])
        );
    end

    sar_resolve #(.NR(NR), .IW(IW)) u_res (
        .hits(hits), .sc(reg_sc), .unit_en(unit_en), .fb_ns(fb_ns),
        .attr(lk_attr), .hit(lk_hit), .idx(lk_idx), .overlap(lk_ov)
    );

    typedef struct packed {
        logic          valid;
        logic [1:0]    attr;
        logic          hit;
        logic [IW-1:0] idx;
        logic          overlap;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d.valid   = q_valid;
        res_d.attr    = lk_attr;
        res_d.hit     = lk_hit;
        res_d.idx     = lk_idx;
        res_d.overlap = lk_ov;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign r_valid   = res_q.valid;
    assign r_attr    = res_q.attr;
    assign r_hit     = res_q.hit;
    assign r_idx     = res_q.idx;
    assign r_overlap = res_q.overlap;
endmodule

// File: rtl/sar_checker_sva.sv
module sar_checker_sva #(
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          q_valid,
    input logic          r_valid,
    input logic [1:0]    r_attr,
    input logic          r_hit,
    input logic [IW-1:0] r_idx,
    input logic          r_overlap,
    input logic          unit_en,
    input logic          fb_ns
);
    AST_QUERY_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> r_valid); // R8
    AST_NO_QUERY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !r_valid); // R8
    AST_OFF_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !unit_en) |=> (!r_hit && !r_overlap && r_idx == '0
                                   && r_attr == ($past(fb_ns) ? 2'd1 : 2'd0))); // R4
    AST_MISS_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && unit_en) |=> (r_hit || (r_attr == 2'd0 && r_idx == '0))); // R6
    AST_OVERLAP_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_overlap) |-> (r_hit && r_attr == 2'd0)); // R7
    AST_ATTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> (r_attr != 2'd3)); // R3
    AST_CALLABLE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_attr == 2'd2) |-> r_hit); // R3
endmodule

bind sar_checker sar_checker_sva #(.IW(IW)) u_sva (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .r_valid(r_valid),
    .r_attr(r_attr), .r_hit(r_hit), .r_idx(r_idx), .r_overlap(r_overlap),
    .unit_en(unit_en), .fb_ns(fb_ns)
);

// File: tb/sim_sar_checker.sv
module sim_sar_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        q_valid = 1'b0;
    logic [31:0] q_addr = '0;

    logic        r_valid, r_hit, r_overlap;
    logic [1:0]  r_attr, r_idx;
    logic        r1_valid, r1_hit, r1_overlap;
    logic [1:0]  r1_attr;
    logic [0:0]  r1_idx;

    int total = 0;
    int bad   = 0;
    bit g_fb  = 1'b0;

    typedef struct {
        logic [1:0] attr;
        logic       hit;
        logic [1:0] idx;
        logic       ov;
        logic [1:0] attr1;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    sar_checker #(.NREG(4), .AW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .q_valid(q_valid),
        .q_addr(q_addr), .r_valid(r_valid), .r_attr(r_attr), .r_hit(r_hit),
        .r_idx(r_idx), .r_overlap(r_overlap)
    );

    sar_checker #(.NREG(0), .AW(32)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx[0:0]), .cfg_wdata(cfg_wdata), .q_valid(q_valid),
        .q_addr(q_addr), .r_valid(r1_valid), .r_attr(r1_attr), .r_hit(r1_hit),
        .r_idx(r1_idx), .r_overlap(r1_overlap)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one configuration write for one cycle
    task automatic cfg_write(logic [1:0] sel, logic [1:0] idx, logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd3) g_fb = data[1];
    endtask

    // drive one query; push the expected result into the scoreboard
    task automatic query(logic [31:0] a, logic [1:0] attr, logic hit,
                         logic [1:0] idx, logic ov, string tag);
        exp_t e;
        e.attr = attr; e.hit = hit; e.idx = idx; e.ov = ov;
        e.attr1 = g_fb ? 2'd1 : 2'd0;
        e.tag = tag;
        sb.push_back(e);
        q_valid = 1'b1; q_addr = a;
        @(negedge clk);
        q_valid = 1'b0;
    endtask

    // monitor: compares results as they emerge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && r_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8", "unexpected r_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(r_attr == e.attr, e.tag, "attr", r_attr, e.attr);
                    check(r_hit == e.hit, e.tag, "hit", r_hit, e.hit);
                    check(r_idx == e.idx, e.tag, "idx", r_idx, e.idx);
                    check(r_overlap == e.ov, e.tag, "overlap", r_overlap, e.ov);
                    check(r1_valid && r1_attr == e.attr1 && !r1_hit, "R5",
                          "absent-unit attr", r1_attr, e.attr1);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(r_valid == 1'b0, "R10", "r_valid after reset", r_valid, 0);
        check(r_hit == 1'b0, "R10", "r_hit after reset", r_hit, 0);

        // unit off at reset, fallback secure
        query(32'h1000_2000, 2'd0, 0, 0, 0, "R4");
        // R2: regions enabled at reset, all spanning 0..0 -> overlap at address 0
        cfg_write(2'd3, 0, 32'h1);
        query(32'h0000_0000, 2'd0, 1, 0, 1, "R2");
        query(32'h0000_0004, 2'd0, 0, 0, 0, "R6");
        // unit off with non-secure fallback
        cfg_write(2'd3, 0, 32'h2);
        query(32'h1000_2000, 2'd1, 0, 0, 0, "R4");
        @(negedge clk);
        // R8: idle cycle produced no result
        check(sb.size() == 0, "R8", "queue drained", sb.size(), 0);

        // R11 example layout; regions 2,3 disabled
        cfg_write(2'd0, 0, 32'h1000_1000);
        cfg_write(2'd1, 0, 32'h1000_5000);
        cfg_write(2'd2, 0, 32'h1);
        cfg_write(2'd0, 1, 32'h1000_6000);
        cfg_write(2'd1, 1, 32'h1000_8000);
        cfg_write(2'd2, 1, 32'h3);
        cfg_write(2'd2, 2, 32'h0);
        cfg_write(2'd2, 3, 32'h0);
        cfg_write(2'd3, 0, 32'h1);

        query(32'h1000_1000, 2'd1, 1, 0, 0, "R1");
        query(32'h1000_5000, 2'd1, 1, 0, 0, "R1");
        query(32'h1000_5001, 2'd0, 0, 0, 0, "R6");
        query(32'h1000_0FFF, 2'd0, 0, 0, 0, "R1");
        query(32'h1000_7000, 2'd2, 1, 1, 0, "R11");
        query(32'h1000_8000, 2'd2, 1, 1, 0, "R3");
        query(32'h1000_8004, 2'd0, 0, 0, 0, "R6");
        query(32'h1000_3000, 2'd1, 1, 0, 0, "R11");

        // R7 overlap
        cfg_write(2'd0, 2, 32'h1000_4000);
        cfg_write(2'd1, 2, 32'h1000_6800);
        cfg_write(2'd2, 2, 32'h3);
        query(32'h1000_4800, 2'd0, 1, 0, 1, "R7");
        query(32'h1000_6400, 2'd0, 1, 1, 1, "R7");
        query(32'h1000_5800, 2'd2, 1, 2, 0, "R3");
        // R2 disabled region no longer matches
        cfg_write(2'd2, 2, 32'h2);
        query(32'h1000_5800, 2'd0, 0, 0, 0, "R2");

        // R9: write and query in the same cycle sees old config
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_idx = 2'd0; cfg_wdata = 32'h0;
        query(32'h1000_2000, 2'd1, 1, 0, 0, "R9");
        cfg_we = 1'b0;
        query(32'h1000_2000, 2'd0, 0, 0, 0, "R9");

        // R4 unit off overrides configured regions
        cfg_write(2'd3, 0, 32'h2);
        query(32'h1000_7000, 2'd1, 0, 0, 0, "R4");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R8", "all results seen", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule